// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller pulses a start strobe together with the first column, the current 11-bit mode word and a read/write flag. From that point the block emits one column per accepted beat until the burst is complete, a burst-stop strobe arrives, or a new start replaces the burst. The mode word selects the burst length and the ordering, sequential or interleaved, and can force writes down to a single location.

The column output is a valid/ready stream. `col_valid` together with `col_addr` and `col_last` describes the current beat. The beat is consumed on a rising edge where `col_ready` is high. While `col_valid` is high and `col_ready` is low, all three outputs hold their values. `col_ready` acts only as the advance enable. It never cancels a burst. Start and stop are plain control strobes and are never back-pressured.

The block decodes the mode word only on the start edge. Changing the mode word during a burst has no effect until the next start.

Top module: `colgen_burst_addr`

## Requirements
- R1: When `start` is high on an edge, `col_valid` is high in the next cycle and `col_addr` equals the `start_col` sampled on that edge. This applies even when another burst is still running, and the running burst is abandoned.
- R2: In sequential order (mode bit 3 = 0), beat i carries the column whose low log2(BL) bits are (start + i) mod BL. The upper bits stay equal to those of the start column. For example, start 0x2E with length 8 gives 2E,2F,28,29,2A,2B,2C,2D.
- R3: In interleaved order (mode bit 3 = 1), beat i carries the start column with its low log2(BL) bits XORed with i. For example, start 0x05 with length 8 gives 05,04,07,06,01,00,03,02.
- R4: Mode bits [2:0] set the burst length (BL): 000 = 1, 001 = 2, 010 = 4, 011 = 8. The burst produces exactly BL beats.
- R5: Code 111 with sequential order selects a full-page burst. The column advances by one modulo 256 across the whole row, `col_last` never rises, and the burst continues until it is stopped or restarted.
- R6: A reserved length code (100, 101, 110, or 111 with interleaved order) gives a one-beat burst. `mode_err` is high from the first beat until the next start that loads a legal code.
- R7: When mode bit 9 is set and `is_write` is high at start, the burst is a single beat. A read with the same mode word keeps the programmed length.
- R8: `col_last` is high only on the final beat of a burst of finite length. After that beat is accepted, `col_valid` is low in the next cycle unless a new start arrived.
- R9: While `col_valid` is high and `col_ready` is low, `col_valid`, `col_addr` and `col_last` keep their values on the following cycle, provided there is no start or stop.
- R10: If `stop` is high on an edge and `start` is not, `col_valid` is low in the next cycle. If both are high, the start wins, as described in R1.
- R11: During reset and until the first start, `col_valid`, `col_last` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 11 | Mode word, decoded on the start edge |
| is_write | input | 1 | Burst is a write (sampled at start) |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| stop | input | 1 | End the current burst |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A beat is presented |
| col_addr | output | 8 | Column of the current beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Burst was loaded with a reserved length code |

## Verification
A corrupted beat index or a wrong latched base shows up on `col_addr` in the very next beat. The bench compares every beat of every burst, so a fault becomes visible within one cycle of the accepted beat. A wrong length or a faulty terminal compare appears as `col_last` on the wrong beat, or as `col_valid` staying high or dropping one cycle off. This is visible at most one beat after the expected end. Full-page bursts are run past the 256-column wrap, which exposes a counter that saturates or asserts last. Stalls of several cycles expose an index that moves without a handshake.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int MODE_W = 11;
  localparam int BL_LSB = 0;
  localparam int BL_MSB = 2;
  localparam int BT_BIT = 3;   // ordering select
  localparam int WB_BIT = 9;   // single-location write select

  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } blen_code_e;

  // Decoded burst configuration captured at start
  typedef struct packed {
    logic [1:0] lg;    // log2 of finite burst length
    logic       full;  // row-length burst
    logic       ilv;   // interleaved ordering
    logic       err;   // reserved length code seen
  } burst_cfg_t;
endpackage

// File: rtl/colgen_mode_decode.sv
module colgen_mode_decode
  import colgen_pkg::*;
(
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_write,
  output burst_cfg_t        cfg
);
  logic unused_mode_bits;
  assign unused_mode_bits = ^{mode_word[MODE_W-1:WB_BIT+1], mode_word[WB_BIT-1:BT_BIT+1]};

  always_comb begin
    cfg     = '0;
    cfg.ilv = mode_word[BT_BIT];
    case (mode_word[BL_MSB:BL_LSB])
      BLC_1:    cfg.lg = 2'd0;                   // R4
      BLC_2:    cfg.lg = 2'd1;
      BLC_4:    cfg.lg = 2'd2;
      BLC_8:    cfg.lg = 2'd3;
      BLC_PAGE: begin
        if (mode_word[BT_BIT]) cfg.err  = 1'b1;  // R6: page + interleave
        else                   cfg.full = 1'b1;  // R5
      end
      default:  cfg.err = 1'b1;                  // R6: reserved -> one beat
    endcase
    if (is_write && mode_word[WB_BIT]) begin     // R7
      cfg.lg   = 2'd0;
      cfg.full = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             ready,
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       cfg_in,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] base,
  output burst_cfg_t       cfg_q,
  output logic             last
);
  logic [COL_W-1:0] lenm1;

  always_comb begin
    lenm1 = ~({COL_W{1'b1}} << cfg_q.lg);
    last  = active && !cfg_q.full && (idx == lenm1);   // R8, R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      cfg_q  <= '0;
    end else if (start) begin                  // R1: start wins over stop
      active <= 1'b1;
      idx    <= '0;
      base   <= start_col;
      cfg_q  <= cfg_in;
    end else if (stop) begin                   // R10
      active <= 1'b0;
    end else if (active && ready) begin        // R9: advance only on handshake
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;          // wraps the row in page mode
    end
  end

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !active);                                  // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last && ready && !start |=> !active);                         // R8
  AST_STALL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    active && !ready && !start && !stop |=> active && $stable(idx)); // R9
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    mask = ~({COL_W{1'b1}} << cfg.lg);
    sum  = base + idx;
    if (cfg.full)     col = sum;                                // R5
    else if (cfg.ilv) col = base ^ (idx & mask);                // R3
    else              col = (base & ~mask) | (sum & mask);      // R2
  end
endmodule

// File: rtl/colgen_burst_addr.sv
module colgen_burst_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_write,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  input  logic              col_ready,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last,
  output logic              mode_err
);
  burst_cfg_t       cfg_dec;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] base;
  logic             active;
  logic             last;

  colgen_mode_decode u_dec (
    .mode_word (mode_word),
    .is_write  (is_write),
    .cfg       (cfg_dec)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .ready     (col_ready),
    .start_col (start_col),
    .cfg_in    (cfg_dec),
    .active    (active),
    .idx       (idx),
    .base      (base),
    .cfg_q     (cfg_q),
    .last      (last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .idx  (idx),
    .cfg  (cfg_q),
    .col  (col_addr)
  );

  assign col_valid = active;
  assign col_last  = last;
  assign mode_err  = cfg_q.err;   // R6

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_addr == $past(start_col)));       // R1
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !start && !stop |=>
      col_valid && $stable(col_addr) && $stable(col_last));       // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && mode_err |-> col_last);                          // R6
endmodule

// File: tb/tb_colgen_burst_addr.sv
module tb_colgen_burst_addr;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [10:0]      mode_word = '0;
  logic             is_write = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic             col_ready = 1'b0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             mode_err;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  colgen_burst_addr #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .is_write(is_write),
    .start(start), .start_col(start_col), .stop(stop), .col_ready(col_ready),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .mode_err(mode_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(int b, int i, int lg, bit ilv, bit full);
    int m = (1 << lg) - 1;
    if (full)     return (b + i) & 255;
    else if (ilv) return b ^ (i & m);
    else          return (b & ~m & 255) | ((b + i) & m);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start_burst(int mode, bit wr, int col);
    mode_word = 11'(mode); is_write = wr; start_col = 8'(col); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run_burst(string req, int mode, bit wr, int col, int lg,
                           bit ilv, bit err_exp);
    int n = 1 << lg;
    col_ready = 1'b1;
    start_burst(mode, wr, col);
    mode_word = 11'h7FF;   // later changes must not matter
    for (int i = 0; i < n; i++) begin
      chk(req, "valid", int'(col_valid), 1);
      chk(req, "addr", int'(col_addr), exp_col(col, i, lg, ilv, 1'b0));
      chk(req, "last", int'(col_last), int'(i == n - 1));
      chk(req, "err", int'(mode_err), int'(err_exp));
      tick();
    end
    chk(req, "valid after last (R8)", int'(col_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R11", "valid in reset", int'(col_valid), 0);
    chk("R11", "last in reset", int'(col_last), 0);
    chk("R11", "err in reset", int'(mode_err), 0);
    rst_n = 1'b1;
    tick();
    chk("R11", "valid idle", int'(col_valid), 0);
  endtask

  task automatic t_lengths();
    run_burst("R2_R4_len8", 11'b011, 1'b0, 8'h2E, 3, 1'b0, 1'b0);
    run_burst("R2_R4_len4", 11'b010, 1'b0, 8'h13, 2, 1'b0, 1'b0);
    run_burst("R4_len2", 11'b001, 1'b0, 8'h41, 1, 1'b0, 1'b0);
    run_burst("R4_len1", 11'b000, 1'b1, 8'h77, 0, 1'b0, 1'b0);
    run_burst("R2_R8_len8", 11'b011, 1'b1, 8'h06, 3, 1'b0, 1'b0);
  endtask

  task automatic t_interleave();
    run_burst("R3_len8", 11'b1011, 1'b0, 8'h05, 3, 1'b1, 1'b0);
    run_burst("R3_len4", 11'b1010, 1'b1, 8'hA6, 2, 1'b1, 1'b0);
    run_burst("R3_len2", 11'b1001, 1'b0, 8'hF3, 1, 1'b1, 1'b0);
  endtask

  task automatic t_full_page();
    col_ready = 1'b1;
    start_burst(11'b0111, 1'b0, 8'hFE);
    for (int i = 0; i < 260; i++) begin
      chk("R5", "page valid", int'(col_valid), 1);
      chk("R5", "page addr", int'(col_addr), (8'hFE + i) & 255);
      chk("R5", "page last", int'(col_last), 0);
      tick();
    end
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R10", "valid after page stop", int'(col_valid), 0);
  endtask

  task automatic t_reserved();
    run_burst("R6_code100", 11'b100, 1'b0, 8'h31, 0, 1'b0, 1'b1);
    run_burst("R6_code110", 11'b1110, 1'b0, 8'h32, 0, 1'b0, 1'b1);
    run_burst("R6_page_ilv", 11'b1111, 1'b0, 8'h33, 0, 1'b0, 1'b1);
    tick();
    chk("R6", "err held when idle", int'(mode_err), 1);
    run_burst("R6_err_clear", 11'b010, 1'b0, 8'h34, 2, 1'b0, 1'b0);
  endtask

  task automatic t_single_write();
    run_burst("R7_write", 11'h200 | 11'b011, 1'b1, 8'h5C, 0, 1'b0, 1'b0);
    run_burst("R7_read", 11'h200 | 11'b011, 1'b0, 8'h5C, 3, 1'b0, 1'b0);
    run_burst("R7_write_page", 11'h200 | 11'b111, 1'b1, 8'h80, 0, 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    col_ready = 1'b0;
    start_burst(11'b010, 1'b0, 8'h20);
    for (int k = 0; k < 3; k++) begin
      chk("R9", "stall valid", int'(col_valid), 1);
      chk("R9", "stall addr", int'(col_addr), 8'h20);
      tick();
    end
    col_ready = 1'b1; tick();
    chk("R9", "advance addr", int'(col_addr), 8'h21);
    col_ready = 1'b0; tick();
    chk("R9", "stall addr2", int'(col_addr), 8'h21);
    col_ready = 1'b1; tick(); tick();
    chk("R9", "beat3 addr", int'(col_addr), 8'h23);
    chk("R8", "beat3 last", int'(col_last), 1);
    col_ready = 1'b0; tick(); tick();
    chk("R9", "last held", int'(col_last), 1);
    chk("R9", "last valid held", int'(col_valid), 1);
    col_ready = 1'b1; tick();
    chk("R8", "valid after last", int'(col_valid), 0);
  endtask

  task automatic t_stop_restart();
    col_ready = 1'b1;
    start_burst(11'b011, 1'b0, 8'h40);
    tick();
    chk("R10", "pre-stop addr", int'(col_addr), 8'h41);
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R10", "valid after stop", int'(col_valid), 0);
    tick();
    chk("R10", "still idle", int'(col_valid), 0);
    start_burst(11'b011, 1'b0, 8'h40);
    tick();
    start_burst(11'b010, 1'b0, 8'h92);
    chk("R1", "restart valid", int'(col_valid), 1);
    chk("R1", "restart addr", int'(col_addr), 8'h92);
    tick();
    chk("R1", "restart beat1", int'(col_addr), 8'h93);
    tick(); tick();
    chk("R1", "restart beat3", int'(col_addr), 8'h91);
    chk("R1", "restart last", int'(col_last), 1);
    stop = 1'b1;
    start_burst(11'b000, 1'b0, 8'h55);
    stop = 1'b0;
    chk("R10", "start beats stop valid", int'(col_valid), 1);
    chk("R10", "start beats stop addr", int'(col_addr), 8'h55);
    tick();
    chk("R10", "one beat done", int'(col_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lengths();
    t_interleave();
    t_full_page();
    t_reserved();
    t_single_write();
    t_stall();
    t_stop_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule